// File: doc/BRIEF.md
# Dual-Width Byte Transmit FIFO

This block is the byte queue that sits in front of the serial engine of a two-wire controller. A 32-bit peripheral bus writes into it through two write-only ports that share one set of bus signals. A select bit chooses between a narrow port that adds one byte per access and a wide port that adds two bytes per access. The serial engine removes bytes one at a time from the far side, in the order they arrived.

A write that does not fit is never dropped or flagged. The block raises a wait signal, and the bus holds the access until enough room exists. The free space counted for this decision includes a byte that the engine removes in the same cycle. A two-bit fill code is updated at every clock edge, so after each completed access it describes the new fill level. Reset is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `dual_tx_fifo`

## Requirements
- R1: During reset and once it is released, the queue is empty: `tx_status` reads 00, `eng_valid` is 0 and `bus_wait` is 0.
- R2: A completed write with `bus_sel`=0 adds one byte, taken from `bus_wdata[7:0]`. Bits 31:8 are ignored.
- R3: A completed write with `bus_sel`=1 adds two bytes in one edge. `bus_wdata[7:0]` is queued first and `bus_wdata[15:8]` second. Bits 31:16 are ignored.
- R4: Bytes reach `eng_data` strictly in arrival order, across any mix of narrow writes, wide writes and pops.
- R5: `tx_status` encodes the fill level after each edge: 00 means empty, 11 means full (DEPTH bytes), and 01 means any other level. Code 10 never appears.
- R6: A narrow write while the queue is full, with no pop in that cycle, keeps `bus_wait` high and leaves the contents unchanged. The write completes at the first edge where one byte is free.
- R7: A wide write waits while fewer than two bytes are free, counting a same-cycle pop, and completes at the first edge where two are free.
- R8: A pop issued in the same cycle as a pending write frees its byte first. A narrow write to a full queue therefore completes on that same edge, with `bus_wait` low.
- R9: `eng_pop` while the queue is empty has no effect: the status stays 00 and the next byte written is the next byte presented.
- R10: While `bus_wr_en` is 0, changes on `bus_sel` and `bus_wdata` add nothing and `bus_wait` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_en | input | 1 | Bus write access active; held until `bus_wait` is low |
| bus_sel | input | 1 | 0 selects the one-byte port, 1 selects the two-byte port |
| bus_wdata | input | 32 | Bus write data |
| bus_wait | output | 1 | Access stalled for lack of space |
| tx_status | output | 2 | Fill code: 00 empty, 01 partial, 11 full |
| eng_pop | input | 1 | Serial engine takes the head byte |
| eng_valid | output | 1 | A byte is present at `eng_data` |
| eng_data | output | 8 | Head byte |

## Verification
A wrong fill count shows at the ports within one cycle. The fill code goes stale, or `bus_wait` stalls a write that has room, or lets through a write that does not. A corrupted write or read pointer does not show until the affected byte reaches the head. Each scenario therefore drains the queue completely and compares every byte in order. The stall cases are probed one edge before and on the edge where space frees, with and without a same-cycle pop, because an off-by-one in the space test changes `bus_wait` only on those edges.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    TXS_EMPTY = 2'b00,
    TXS_PART  = 2'b01,
    TXS_FULL  = 2'b11
  } txs_e;

  typedef enum logic {
    PORT_BYTE = 1'b0,
    PORT_HALF = 1'b1
  } port_e;

  localparam int unsigned MAX_LANES = 2;
endpackage

// File: rtl/txf_rst_sync.sv
module txf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/txf_space.sv
module txf_space
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] fill,
  input  logic          wr_req,
  input  port_e         port,
  input  logic          pop_req,
  output logic          pop_fire,
  output logic [1:0]    push_cnt,
  output logic          stall
);
  localparam logic [CW:0] DEPTH_W = (CW+1)'(DEPTH);

  logic [CW:0] free_now;
  logic [CW:0] free_eff;
  logic [CW:0] need;
  logic        fits;

  always_comb begin
    pop_fire = pop_req && (fill != '0);
    need     = (port == PORT_HALF) ? (CW+1)'(2) : (CW+1)'(1);
    free_now = DEPTH_W - {1'b0, fill};
    free_eff = free_now + (CW+1)'(pop_fire);
    fits     = (free_eff >= need);
    stall    = wr_req && !fits;
    if (wr_req && fits) push_cnt = (port == PORT_HALF) ? 2'd2 : 2'd1;
    else                push_cnt = 2'd0;
  end
endmodule

// File: rtl/txf_store.sv
module txf_store #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned PW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    push_cnt,
  input  logic [7:0]    din_first,
  input  logic [7:0]    din_second,
  input  logic          pop_fire,
  output logic [7:0]    head,
  output logic [CW-1:0] fill
);
  localparam logic [PW:0] DEPTH_P = (PW+1)'(DEPTH);

  function automatic logic [PW-1:0] ptr_add(input logic [PW-1:0] p,
                                            input logic [1:0]    step);
    logic [PW:0] sum;
    sum = {1'b0, p} + (PW+1)'(step);
    if (sum >= DEPTH_P) sum = sum - DEPTH_P;
    return sum[PW-1:0];
  endfunction

  logic [7:0]    slot_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, wptr_nxt1;
  logic [PW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          state_en;

  always_comb begin
    wptr_nxt1 = ptr_add(wptr_q, 2'd1);
    wptr_d    = ptr_add(wptr_q, push_cnt);
    rptr_d    = pop_fire ? ptr_add(rptr_q, 2'd1) : rptr_q;
    fill_d    = fill_q + CW'(push_cnt) - CW'(pop_fire);
    state_en  = (push_cnt != 2'd0) || pop_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else if (state_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      fill_q <= fill_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic       we_first;
    logic       we_second;
    logic       slot_en;
    logic [7:0] slot_d;

    always_comb begin
      we_first  = (push_cnt != 2'd0) && (wptr_q == PW'(gi));
      we_second = (push_cnt == 2'd2) && (wptr_nxt1 == PW'(gi));
      slot_en   = we_first || we_second;
      slot_d    = we_first ? din_first : din_second;
    end

    always_ff @(posedge clk) begin
      if (slot_en) slot_q[gi] <= slot_d;
    end
  end

  assign head = slot_q[rptr_q];
  assign fill = fill_q;
endmodule

// File: rtl/dual_tx_fifo.sv
module dual_tx_fifo
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic        bus_wait,
  output logic [1:0]  tx_status,
  input  logic        eng_pop,
  output logic        eng_valid,
  output logic [7:0]  eng_data
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          rst_sync_n;
  logic [CW-1:0] fill_cnt;
  logic [1:0]    push_cnt;
  logic          pop_fire;
  port_e         port;
  txs_e          status;
  logic          unused_upper_bits;

  assign port              = port_e'(bus_sel);
  assign unused_upper_bits = ^bus_wdata[31:16];

  txf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  txf_space #(.DEPTH(DEPTH), .CW(CW)) u_space (
    .fill     (fill_cnt),
    .wr_req   (bus_wr_en),
    .port     (port),
    .pop_req  (eng_pop),
    .pop_fire (pop_fire),
    .push_cnt (push_cnt),
    .stall    (bus_wait)
  );

  txf_store #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push_cnt   (push_cnt),
    .din_first  (bus_wdata[7:0]),
    .din_second (bus_wdata[15:8]),
    .pop_fire   (pop_fire),
    .head       (eng_data),
    .fill       (fill_cnt)
  );

  always_comb begin
    if (fill_cnt == '0)          status = TXS_EMPTY;
    else if (fill_cnt == DEPTH_C) status = TXS_FULL;
    else                          status = TXS_PART;
  end

  assign tx_status = status;
  assign eng_valid = (fill_cnt != '0);
endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          bus_wr_en,
  input logic          bus_sel,
  input logic          bus_wait,
  input logic [1:0]    tx_status,
  input logic          eng_pop,
  input logic          eng_valid,
  input logic [CW-1:0] fill_cnt
);
  localparam logic [CW-1:0] LAST_FREE = CW'(DEPTH - 1);

  a_r1_valid_matches_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eng_valid == (tx_status != 2'b00));

  a_r5_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_status != 2'b10);

  a_r2_byte_adds_one: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_en && !bus_sel && !bus_wait && !(eng_pop && eng_valid))
    |=> fill_cnt == $past(fill_cnt) + CW'(1));

  a_r3_half_adds_two: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_en && bus_sel && !bus_wait && !(eng_pop && eng_valid))
    |=> fill_cnt == $past(fill_cnt) + CW'(2));

  a_r6_full_byte_stalls: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_en && !bus_sel && tx_status == 2'b11 && !eng_pop) |-> bus_wait);

  a_r6_stall_keeps_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wait && !eng_pop) |=> fill_cnt == $past(fill_cnt));

  a_r7_half_needs_two: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_en && bus_sel && fill_cnt == LAST_FREE && !eng_pop) |-> bus_wait);

  a_r8_pop_frees_first: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_en && !bus_sel && tx_status == 2'b11 && eng_pop) |-> !bus_wait);

  a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_pop && !eng_valid && !bus_wr_en) |=> tx_status == 2'b00);

  a_r10_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_wr_en |-> !bus_wait);
endmodule

bind dual_tx_fifo txf_checker #(.DEPTH(DEPTH), .CW(CW)) u_txf_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_wr_en  (bus_wr_en),
  .bus_sel    (bus_sel),
  .bus_wait   (bus_wait),
  .tx_status  (tx_status),
  .eng_pop    (eng_pop),
  .eng_valid  (eng_valid),
  .fill_cnt   (fill_cnt)
);

// File: tb/dual_tx_fifo_bench.sv
module dual_tx_fifo_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_wr_en;
  logic        bus_sel;
  logic [31:0] bus_wdata;
  logic        bus_wait;
  logic [1:0]  tx_status;
  logic        eng_pop;
  logic        eng_valid;
  logic [7:0]  eng_data;

  int checks;
  int errors;
  bit done;

  dual_tx_fifo u_dual_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_wait  (bus_wait),
    .tx_status (tx_status),
    .eng_pop   (eng_pop),
    .eng_valid (eng_valid),
    .eng_data  (eng_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr_en = 1'b0;
    eng_pop   = 1'b0;
  endtask

  task automatic drive_wr(input logic sel, input logic [31:0] d);
    bus_wr_en = 1'b1;
    bus_sel   = sel;
    bus_wdata = d;
  endtask

  task automatic write_now(input string req, input logic sel, input logic [31:0] d);
    drive_wr(sel, d);
    #1 chk(req, "wait on write with room", 32'(bus_wait), 32'd0);
    tick();
    idle();
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    #1;
    chk(req, "valid before pop", 32'(eng_valid), 32'd1);
    chk(req, "head byte", 32'(eng_data), 32'(exp));
    eng_pop = 1'b1;
    tick();
    eng_pop = 1'b0;
  endtask

  task automatic status_is(input string req, input logic [1:0] exp);
    #1 chk(req, "tx_status", 32'(tx_status), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R1", "status after reset", 32'(tx_status), 32'd0);
    chk("R1", "valid after reset", 32'(eng_valid), 32'd0);
    chk("R1", "wait after reset", 32'(bus_wait), 32'd0);
  endtask

  task automatic t_byte_port();
    write_now("R2", 1'b0, 32'hDEADBE11);
    status_is("R5", 2'b01);
    pop_expect("R2", 8'h11);
    status_is("R5", 2'b00);
  endtask

  task automatic t_half_port();
    write_now("R3", 1'b1, 32'h1234A55A);
    status_is("R5", 2'b11);
    pop_expect("R3", 8'h5A);
    status_is("R3", 2'b01);
    pop_expect("R3", 8'hA5);
    status_is("R3", 2'b00);
  endtask

  task automatic t_order();
    write_now("R4", 1'b0, 32'h0000000A);
    write_now("R4", 1'b0, 32'h0000000B);
    status_is("R4", 2'b11);
    pop_expect("R4", 8'h0A);
    write_now("R4", 1'b0, 32'h0000000C);
    pop_expect("R4", 8'h0B);
    pop_expect("R4", 8'h0C);
    status_is("R4", 2'b00);
  endtask

  task automatic t_byte_stall();
    write_now("R6", 1'b1, 32'h00002211);
    drive_wr(1'b0, 32'h00000033);
    for (int i = 0; i < 3; i++) begin
      #1 chk("R6", "wait while full", 32'(bus_wait), 32'd1);
      tick();
      status_is("R6", 2'b11);
      chk("R6", "head unchanged", 32'(eng_data), 32'h11);
    end
    eng_pop = 1'b1;
    #1 chk("R8", "wait drops with same-cycle pop", 32'(bus_wait), 32'd0);
    tick();
    idle();
    status_is("R8", 2'b11);
    pop_expect("R8", 8'h22);
    pop_expect("R8", 8'h33);
    status_is("R8", 2'b00);
  endtask

  task automatic t_half_stall();
    write_now("R7", 1'b0, 32'h00000044);
    drive_wr(1'b1, 32'h00006655);
    #1 chk("R7", "wide write waits with one free", 32'(bus_wait), 32'd1);
    tick();
    status_is("R7", 2'b01);
    eng_pop = 1'b1;
    #1 chk("R7", "wide write fits with pop", 32'(bus_wait), 32'd0);
    chk("R7", "head before pop", 32'(eng_data), 32'h44);
    tick();
    idle();
    status_is("R7", 2'b11);
    pop_expect("R7", 8'h55);
    pop_expect("R7", 8'h66);
    write_now("R7", 1'b1, 32'h00008877);
    drive_wr(1'b1, 32'h0000AA99);
    eng_pop = 1'b1;
    #1 chk("R7", "full plus pop still short", 32'(bus_wait), 32'd1);
    chk("R7", "head first", 32'(eng_data), 32'h77);
    tick();
    eng_pop = 1'b0;
    status_is("R7", 2'b01);
    chk("R7", "wait with one free no pop", 32'(bus_wait), 32'd1);
    chk("R7", "head second", 32'(eng_data), 32'h88);
    eng_pop = 1'b1;
    #1 chk("R7", "wide write completes", 32'(bus_wait), 32'd0);
    tick();
    idle();
    pop_expect("R7", 8'h99);
    pop_expect("R7", 8'hAA);
    status_is("R7", 2'b00);
  endtask

  task automatic t_empty_pop();
    eng_pop = 1'b1;
    tick();
    tick();
    eng_pop = 1'b0;
    status_is("R9", 2'b00);
    chk("R9", "valid after empty pops", 32'(eng_valid), 32'd0);
    write_now("R9", 1'b0, 32'h00000077);
    pop_expect("R9", 8'h77);
    status_is("R9", 2'b00);
  endtask

  task automatic t_idle_bus();
    write_now("R10", 1'b0, 32'h0000005C);
    for (int i = 0; i < 3; i++) begin
      bus_sel   = ~bus_sel;
      bus_wdata = 32'hC0DE0000 + 32'(i);
      tick();
      #1 chk("R10", "no wait while idle", 32'(bus_wait), 32'd0);
    end
    status_is("R10", 2'b01);
    pop_expect("R10", 8'h5C);
    status_is("R10", 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    bus_wr_en = 1'b0;
    bus_sel   = 1'b0;
    bus_wdata = '0;
    eng_pop   = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R1", "status in reset", 32'(tx_status), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_byte_port();
    t_half_port();
    t_order();
    t_byte_stall();
    t_half_stall();
    t_empty_pop();
    t_idle_bus();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule